// File: doc/BRIEF.md
# Atomic Memory Synchronization Unit

This unit sits in front of a small shared word memory and carries out the synchronization primitives that several processors use to build locks, counters and lock-free updates. Every processor presents its own request lane: a valid flag, a 3-bit operation code, a word address and a data word. Each cycle the unit picks one pending lane, performs the complete read-modify-write for it on the memory, and returns the result in the following cycle. Because only one operation touches the memory per cycle, exchange, test-and-set and fetch-and-increment are indivisible.

For the load-linked / store-conditional pair the unit keeps one reservation per processor, made of a valid bit and an address. A load-linked sets the issuer's reservation. Any store that actually changes memory at an address cancels every reservation held on that address. A store-conditional succeeds only if the issuer's reservation is still valid and names the same address.

A requester holds its lane valid until it sees its own grant bit at a clock edge. It then drops or replaces the request, and it picks up the answer on the response port one cycle later. The response is tagged with the processor index.

Top module: `syncUnit`

## Requirements
- R1: After reset the response port is idle, every memory word reads 0, and no processor holds a reservation, so a store-conditional issued first fails with result 0.
- R2: In any cycle, `reqGrant` has at most one bit set. That bit belongs to the lowest-indexed processor whose `reqValid` is high, and no bit is set for a lane that is not valid.
- R3: `rspValid` is high in exactly the cycles that follow a grant, and `rspId` then carries the index of the processor that was granted.
- R4: The operation codes are 0 read, 1 write, 2 exchange, 3 test-and-set, 4 fetch-and-increment, 5 load-linked and 6 store-conditional. Code 7 behaves as a read. A read returns the word and changes nothing. A write stores the data and returns 0.
- R5: An exchange stores the request data and returns the previous word. Used on a lock word where 0 means free, it returns 0 only to the one processor that acquired the lock.
- R6: A test-and-set returns the previous word and stores 1 only if that word was 0. Otherwise memory and all reservations are left untouched.
- R7: A fetch-and-increment returns the previous word and stores that word plus one, wrapping modulo 2^DW.
- R8: A load-linked returns the word and sets the issuer's reservation to that address, replacing any reservation it held before.
- R9: A store-conditional whose issuer holds a valid reservation on the same address stores the data and returns 1. In every other case it returns 0 and leaves memory unchanged.
- R10: Every store-conditional, whether it succeeds or fails, cancels the issuer's reservation.
- R11: Every operation that stores to an address cancels all processors' reservations on that address. This covers writes, exchanges, fetch-and-increments, test-and-sets that store, and successful store-conditionals. Reservations on other addresses are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | NPROC | One request-pending flag per processor |
| reqOp | input | 3*NPROC | Operation code per processor, lane p at bits [3p+2:3p] |
| reqAddr | input | AW*NPROC | Word address per processor, lane p at [AW*p +: AW] |
| reqData | input | DW*NPROC | Store data per processor, lane p at [DW*p +: DW] |
| reqGrant | output | NPROC | Combinational grant, one-hot or zero |
| rspValid | output | 1 | Response present, one cycle after a grant |
| rspId | output | IDW = max(1, clog2(NPROC)) | Index of the processor being answered |
| rspData | output | DW | Previous word, 0 for a write, or the 0/1 store-conditional flag |

## Verification
Lock acquisition is exercised by having all four processors exchange on one lock word in the same cycle. This shows that exactly one requester, the lowest-indexed one, sees 0. Four simultaneous increments, run twice, show that no update is lost. A counter at all ones shows the wrap. The reservation logic is exercised with several sequences, each separating one case from the others:
- a clean load-linked/store-conditional pair;
- a second store-conditional with no new load-linked;
- a foreign store to the linked word, and one to a different word;
- a test-and-set that fails and so must not cancel reservations;
- a re-link to a new address;
- two linked processors racing their store-conditionals in the same cycle.

A long random phase then mixes all operations over four addresses and against a behavioural model.

// File: rtl/syncPkg.sv
package syncPkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_TAS   = 3'd3,
    OP_FINC  = 3'd4,
    OP_LL    = 3'd5,
    OP_SC    = 3'd6,
    OP_RSVD  = 3'd7
  } syncOp_e;

  typedef enum logic [1:0] {
    WSEL_DATA = 2'd0,
    WSEL_ONE  = 2'd1,
    WSEL_INC  = 2'd2
  } wrSel_e;

  typedef enum logic [1:0] {
    RSP_OLD  = 2'd0,
    RSP_ZERO = 2'd1,
    RSP_FLAG = 2'd2
  } rspSel_e;

  // strobes from control to datapath for the operation granted this cycle
  typedef struct packed {
    logic    fire;
    logic    memWr;
    wrSel_e  wrSel;
    logic    linkSet;
    logic    linkDropOwn;
    rspSel_e rspSel;
    logic    flagVal;
  } ctrlStrobe_t;

endpackage

// File: rtl/syncArb.sv
module syncArb #(
  parameter int NPROC = 4,
  localparam int IDW = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic [NPROC-1:0] reqValid,
  output logic [NPROC-1:0] grant,
  output logic             anyGrant,
  output logic [IDW-1:0]   grantId
);

  logic [NPROC:0] taken;
  assign taken[0] = 1'b0;

  for (genvar i = 0; i < NPROC; i++) begin : gPrio
    assign grant[i]   = reqValid[i] & ~taken[i];
    assign taken[i+1] = taken[i] | reqValid[i];
  end

  assign anyGrant = taken[NPROC];

  always_comb begin
    grantId = '0;
    for (int i = NPROC - 1; i >= 0; i--) begin
      if (grant[i]) grantId = IDW'(i);
    end
  end

endmodule

// File: rtl/syncCtrl.sv
module syncCtrl
  import syncPkg::*;
(
  input  logic           anyGrant,
  input  syncOp_e        op,
  input  logic           oldIsZero,
  input  logic           linkHit,
  output ctrlStrobe_t    strobe
);

  always_comb begin
    strobe             = '0;
    strobe.wrSel       = WSEL_DATA;
    strobe.rspSel      = RSP_OLD;
    strobe.fire        = anyGrant;
    if (anyGrant) begin
      unique case (op)
        OP_WRITE: begin
          strobe.memWr  = 1'b1;
          strobe.rspSel = RSP_ZERO;
        end
        OP_SWAP: begin
          strobe.memWr  = 1'b1;
        end
        OP_TAS: begin
          strobe.memWr  = oldIsZero;
          strobe.wrSel  = WSEL_ONE;
        end
        OP_FINC: begin
          strobe.memWr  = 1'b1;
          strobe.wrSel  = WSEL_INC;
        end
        OP_LL: begin
          strobe.linkSet = 1'b1;
        end
        OP_SC: begin
          strobe.linkDropOwn = 1'b1;
          strobe.memWr       = linkHit;
          strobe.rspSel      = RSP_FLAG;
          strobe.flagVal     = linkHit;
        end
        default: begin
          // read and the spare code: plain lookup
        end
      endcase
    end
  end

endmodule

// File: rtl/syncDatapath.sv
module syncDatapath
  import syncPkg::*;
#(
  parameter int NPROC = 4,
  parameter int AW    = 4,
  parameter int DW    = 16,
  localparam int IDW   = (NPROC > 1) ? $clog2(NPROC) : 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctrlStrobe_t    strobe,
  input  logic [IDW-1:0] id,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic           oldIsZero,
  output logic           linkHit,
  output logic           rspValid,
  output logic [IDW-1:0] rspId,
  output logic [DW-1:0]  rspData
);

  logic [DW-1:0] memWords [DEPTH];
  logic          linkValid [NPROC];
  logic [AW-1:0] linkAddr  [NPROC];
  logic [DW-1:0] oldVal;
  logic [DW-1:0] newVal;
  logic [DW-1:0] rspNext;

  assign oldVal    = memWords[addr];
  assign oldIsZero = (oldVal == '0);
  assign linkHit   = linkValid[id] && (linkAddr[id] == addr);

  always_comb begin
    unique case (strobe.wrSel)
      WSEL_ONE: newVal = DW'(1);
      WSEL_INC: newVal = oldVal + DW'(1);
      default:  newVal = wdata;
    endcase
  end

  always_comb begin
    unique case (strobe.rspSel)
      RSP_ZERO: rspNext = '0;
      RSP_FLAG: rspNext = DW'(strobe.flagVal);
      default:  rspNext = oldVal;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH; w++) memWords[w] <= '0;
    end else if (strobe.memWr) begin
      memWords[addr] <= newVal;
    end
  end

  for (genvar p = 0; p < NPROC; p++) begin : gLink
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        linkValid[p] <= 1'b0;
        linkAddr[p]  <= '0;
      end else begin
        if (strobe.memWr && linkAddr[p] == addr) linkValid[p] <= 1'b0;
        if (strobe.fire && id == IDW'(p)) begin
          if (strobe.linkDropOwn) linkValid[p] <= 1'b0;
          if (strobe.linkSet) begin
            linkValid[p] <= 1'b1;
            linkAddr[p]  <= addr;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspId    <= '0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.fire;
      rspId    <= id;
      rspData  <= rspNext;
    end
  end

endmodule

// File: rtl/syncUnit.sv
module syncUnit
  import syncPkg::*;
#(
  parameter int NPROC = 4,
  parameter int AW    = 4,
  parameter int DW    = 16,
  localparam int IDW  = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NPROC-1:0]   reqValid,
  input  logic [3*NPROC-1:0] reqOp,
  input  logic [AW*NPROC-1:0] reqAddr,
  input  logic [DW*NPROC-1:0] reqData,
  output logic [NPROC-1:0]   reqGrant,
  output logic               rspValid,
  output logic [IDW-1:0]     rspId,
  output logic [DW-1:0]      rspData
);

  logic          anyGrant;
  logic [IDW-1:0] selId;
  syncOp_e       selOp;
  logic [AW-1:0] selAddr;
  logic [DW-1:0] selData;
  logic          oldIsZero;
  logic          linkHit;
  ctrlStrobe_t   strobe;

  syncArb #(.NPROC(NPROC)) uArb (
    .reqValid (reqValid),
    .grant    (reqGrant),
    .anyGrant (anyGrant),
    .grantId  (selId)
  );

  assign selOp   = syncOp_e'(reqOp[selId*3 +: 3]);
  assign selAddr = reqAddr[selId*AW +: AW];
  assign selData = reqData[selId*DW +: DW];

  syncCtrl uCtrl (
    .anyGrant  (anyGrant),
    .op        (selOp),
    .oldIsZero (oldIsZero),
    .linkHit   (linkHit),
    .strobe    (strobe)
  );

  syncDatapath #(.NPROC(NPROC), .AW(AW), .DW(DW)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .id        (selId),
    .addr      (selAddr),
    .wdata     (selData),
    .oldIsZero (oldIsZero),
    .linkHit   (linkHit),
    .rspValid  (rspValid),
    .rspId     (rspId),
    .rspData   (rspData)
  );

endmodule

// File: rtl/syncUnitChk.sv
module syncUnitChk #(
  parameter int NPROC = 4,
  parameter int DW    = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [NPROC-1:0] reqValid,
  input logic [NPROC-1:0] reqGrant,
  input logic             rspValid,
  input logic [DW-1:0]    rspData,
  input logic             scFire
);

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqGrant));

  // R2
  grant_lowest_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid[0] |-> reqGrant[0]);

  // R2
  grant_valid_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant & ~reqValid) == '0);

  // R3
  rsp_follows_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|reqGrant) |=> rspValid);

  // R3
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|reqGrant) |=> !rspValid);

  // R9
  sc_flag_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    scFire |=> (rspData <= DW'(1)));

endmodule

bind syncUnit syncUnitChk #(.NPROC(NPROC), .DW(DW)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqGrant (reqGrant),
  .rspValid (rspValid),
  .rspData  (rspData),
  .scFire   (strobe.fire && strobe.rspSel == syncPkg::RSP_FLAG)
);

// File: tb/sim_syncUnit.sv
module sim_syncUnit;

  localparam int NP     = 4;
  localparam int AW     = 4;
  localparam int DW     = 16;
  localparam int IDW    = 2;
  localparam int PERIOD = 10;
  localparam int MASK   = (1 << DW) - 1;
  localparam int WDOG   = 150000;

  typedef struct {
    int op;
    int addr;
    int data;
  } req_t;

  logic              clk;
  logic              rstN;
  logic [NP-1:0]     reqValid;
  logic [3*NP-1:0]   reqOp;
  logic [AW*NP-1:0]  reqAddr;
  logic [DW*NP-1:0]  reqData;
  logic [NP-1:0]     reqGrant;
  logic              rspValid;
  logic [IDW-1:0]    rspId;
  logic [DW-1:0]     rspData;

  syncUnit #(.NPROC(NP), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .reqGrant(reqGrant),
    .rspValid(rspValid), .rspId(rspId), .rspData(rspData)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // behavioural reference
  req_t  q [NP][$];
  int    mdl [1 << AW];
  bit    lv [NP];
  int    la [NP];
  string why [NP];
  bit    expValid;
  int    expId;
  int    expData;
  string expTag;
  string validTag;
  int    checks;
  int    fails;
  bit    done;

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic void killAddr(int a);
    for (int p = 0; p < NP; p++)
      if (lv[p] && la[p] == a) begin
        lv[p]  = 0;
        why[p] = "R11";
      end
  endfunction

  function automatic void model(int p, req_t r);
    int old;
    old      = mdl[r.addr];
    expValid = 1;
    expId    = p;
    case (r.op)
      1: begin mdl[r.addr] = r.data & MASK; killAddr(r.addr); expData = 0; expTag = "R4"; end
      2: begin mdl[r.addr] = r.data & MASK; killAddr(r.addr); expData = old; expTag = "R5"; end
      3: begin
        expData = old; expTag = "R6";
        if (old == 0) begin mdl[r.addr] = 1; killAddr(r.addr); end
      end
      4: begin mdl[r.addr] = (old + 1) & MASK; killAddr(r.addr); expData = old; expTag = "R7"; end
      5: begin expData = old; lv[p] = 1; la[p] = r.addr; why[p] = "R8"; expTag = "R8"; end
      6: begin
        if (lv[p] && la[p] == r.addr) begin
          mdl[r.addr] = r.data & MASK; killAddr(r.addr); expData = 1; expTag = "R9";
        end else begin
          expData = 0;
          expTag  = lv[p] ? "R9" : why[p];
        end
        lv[p]  = 0;
        why[p] = "R10";
      end
      default: begin expData = old; expTag = "R4"; end
    endcase
  endfunction

  task automatic cycle();
    int g;
    logic [NP-1:0] expG;
    @(negedge clk);
    check(validTag, int'(rspValid), int'(expValid), "rspValid");
    if (expValid) begin
      check("R3", int'(rspId), expId, "rspId");
      check(expTag, int'(rspData), expData, "rspData");
    end
    validTag = "R3";
    for (int p = 0; p < NP; p++) begin
      if (q[p].size() > 0) begin
        reqValid[p]          = 1'b1;
        reqOp[p*3 +: 3]      = 3'(q[p][0].op);
        reqAddr[p*AW +: AW]  = AW'(q[p][0].addr);
        reqData[p*DW +: DW]  = DW'(q[p][0].data);
      end else begin
        reqValid[p] = 1'b0;
      end
    end
    #1;
    g    = -1;
    expG = '0;
    for (int p = 0; p < NP; p++)
      if (q[p].size() > 0 && g < 0) g = p;
    if (g >= 0) expG[g] = 1'b1;
    check("R2", int'(reqGrant), int'(expG), "reqGrant");
    if (g >= 0) begin
      model(g, q[g][0]);
      void'(q[g].pop_front());
    end else begin
      expValid = 0;
    end
  endtask

  function automatic bit busy();
    for (int p = 0; p < NP; p++)
      if (q[p].size() > 0) return 1;
    return 0;
  endfunction

  task automatic drain();
    do cycle(); while (busy());
    cycle();
  endtask

  task automatic push(int p, int op, int a, int d);
    req_t r;
    r.op = op; r.addr = a; r.data = d;
    q[p].push_back(r);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(PERIOD * WDOG);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    checks   = 0;
    fails    = 0;
    done     = 0;
    expValid = 0;
    expTag   = "R1";
    validTag = "R1";
    for (int a = 0; a < (1 << AW); a++) mdl[a] = 0;
    for (int p = 0; p < NP; p++) begin lv[p] = 0; la[p] = 0; why[p] = "R1"; end
    rstN     = 1'b0;
    reqValid = '0;
    reqOp    = '0;
    reqAddr  = '0;
    reqData  = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: clean memory and no reservation after reset
    push(0, 0, 3, 0);
    push(1, 6, 3, 5);
    drain();
    push(1, 0, 3, 0);
    drain();

    // R5: four processors race for the lock word
    for (int p = 0; p < NP; p++) push(p, 2, 0, 1);
    drain();
    push(0, 1, 0, 0);
    push(2, 2, 0, 1);
    drain();

    // R6: pass, fail on 1, fail on other value
    push(1, 3, 1, 0);
    push(2, 3, 1, 0);
    push(3, 1, 1, 5);
    push(3, 3, 1, 0);
    push(3, 0, 1, 0);
    drain();

    // R7: simultaneous increments, then wrap at all ones
    for (int k = 0; k < 2; k++)
      for (int p = 0; p < NP; p++) push(p, 4, 2, 0);
    drain();
    push(0, 0, 2, 0);
    push(1, 1, 4, MASK);
    drain();
    push(1, 4, 4, 0);
    push(1, 0, 4, 0);
    drain();

    // R8 R9 R10: clean pair, then a second conditional store
    push(0, 5, 5, 0);
    push(0, 6, 5, 7);
    push(0, 0, 5, 0);
    push(0, 6, 5, 9);
    push(0, 0, 5, 0);
    drain();

    // R11: foreign store on the linked word kills both links
    push(0, 5, 5, 0);
    push(1, 5, 5, 0);
    drain();
    push(2, 1, 5, 3);
    drain();
    push(0, 6, 5, 11);
    push(1, 6, 5, 12);
    drain();
    push(0, 0, 5, 0);
    drain();

    // R11: store elsewhere keeps the link
    push(0, 5, 6, 0);
    drain();
    push(1, 1, 7, 4);
    drain();
    push(0, 6, 6, 21);
    drain();

    // R6 R11: failing test-and-set does not break a link
    push(1, 5, 6, 0);
    drain();
    push(2, 3, 6, 0);
    drain();
    push(1, 6, 6, 22);
    push(1, 0, 6, 0);
    drain();

    // R8: relink moves the reservation
    push(0, 5, 8, 0);
    push(0, 5, 9, 0);
    push(0, 6, 8, 30);
    push(0, 6, 9, 31);
    push(0, 0, 8, 0);
    drain();

    // R9 R11: two links, conditional stores in the same cycle
    push(0, 5, 10, 0);
    push(1, 5, 10, 0);
    drain();
    push(0, 6, 10, 40);
    push(1, 6, 10, 41);
    drain();

    // mixed random traffic on a few words
    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < NP; p++)
        if (q[p].size() < 3 && $urandom_range(0, 2) == 0)
          push(p, $urandom_range(0, 7), $urandom_range(0, 3),
               ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(0, MASK));
      cycle();
    end
    drain();
    for (int a = 0; a < 4; a++) push(3, 0, a, 0);
    drain();

    done = 1;
    summary();
    $finish;
  end

endmodule